// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between an instruction fetch port and a decode stage. Fetch hands it naturally aligned blocks of sixteen instruction bytes. A sideband mask comes with each block and flags every byte that begins an instruction. Instructions have no alignment, so one may begin at any byte and may run on into the following block. The aligner keeps the bytes it has received in a small queue. Each cycle it cuts up to five whole instructions off the front of that queue, in program order. Each instruction is delivered in a slot with its own address, its length and its bytes packed from byte zero.

An instruction's last byte is known only once the next start marker has arrived. Because of that, the final instruction in the queue always waits for more bytes. Fetch is held off whenever the queue could not take a whole block. A redirect throws away everything queued. It also names the byte within the next accepted block at which execution resumes.

Top module: `insn_aligner`

## Requirements
- R1: `fetch_ready` is high exactly when the queue holds at most `QDEPTH - BLK_BYTES` bytes and `redirect` is low. A block is accepted only on a rising edge where both `fetch_valid` and `fetch_ready` are high.
- R2: An instruction runs from a byte whose start bit is 1 (bit j of `fetch_start` belongs to byte j of `fetch_bytes`, bits [8j+7:8j]) up to the byte before the next start bit. It is emitted only once that next start bit is in the queue. Until then it waits.
- R3: Instructions of 1 to 15 bytes that cross from one fetch block into the next are emitted whole, with the correct length in `out_len`.
- R4: At most five instructions are emitted per cycle. Valid slots are packed from slot 0 upward (`out_valid` has the form 0…01…1). Slot k+1 holds the instruction that follows slot k in program order.
- R5: Slot k's byte i sits at `out_bytes[(k*MAX_LEN+i)*8 +: 8]` with the instruction's first byte at i = 0. Bytes at i ≥ length read as zero.
- R6: `out_pc` slot k (`out_pc[k*ADDR_W +: ADDR_W]`) is the address of that instruction's first byte. Byte j of a block taken at address A has address A + j.
- R7: A cycle with `redirect` high empties the queue and accepts no block. `out_valid` reads 0 after that edge. No byte queued before the redirect is emitted afterwards.
- R8: After a redirect with offset n, bytes 0..n-1 of the next accepted block are dropped. The first instruction then has address A + n.
- R9: After reset `out_valid` is 0, the queue is empty and `fetch_ready` is high.
- R10: Outputs are registered. Instructions taken from a block accepted at edge t appear at the earliest after edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch block offered |
| fetch_ready | output | 1 | Aligner can take a block this cycle |
| fetch_addr | input | ADDR_W | Address of byte 0 of the block |
| fetch_bytes | input | 8*BLK_BYTES | Block bytes, byte j at bits [8j+7:8j] |
| fetch_start | input | BLK_BYTES | Per-byte instruction start flags |
| redirect | input | 1 | Flush queue and set resume offset |
| redirect_off | input | log2(BLK_BYTES) | Byte in next block where execution resumes |
| out_valid | output | SLOTS | Per-slot instruction valid |
| out_len | output | SLOTS*LEN_W | Per-slot length in bytes |
| out_pc | output | SLOTS*ADDR_W | Per-slot instruction address |
| out_bytes | output | SLOTS*MAX_LEN*8 | Per-slot bytes, left-aligned, zero padded |

## Verification
The bench uses the default sizes: 16-byte blocks, a 32-byte queue, five slots and a 15-byte length limit. Because the queue holds exactly two blocks, the bench can make `fetch_ready` drop right after a 15-byte instruction has pulled a second block in, and then see it return once that instruction leaves. A block made entirely of one-byte instructions is enough to fill all five slots on three cycles in a row. A stream of mixed lengths exercises instructions that begin at odd offsets and cross block edges.

// File: rtl/insn_align_pkg.sv
package insn_align_pkg;
  localparam int unsigned BYTE_W = 8;

  // mask with the lowest n bits set, for a field of up to 256 bits
  function automatic logic [255:0] low_ones(input int unsigned n);
    logic [255:0] m;
    m = '0;
    for (int i = 0; i < 256; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/aligner_byteq.sv
module aligner_byteq
  import insn_align_pkg::*;
#(
  parameter int BLK    = 16,
  parameter int QDEPTH = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6,
  parameter int OFF_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [ADDR_W-1:0]        push_addr,
  input  logic [BLK*BYTE_W-1:0]    push_bytes,
  input  logic [BLK-1:0]           push_start,
  input  logic                     flush,
  input  logic [OFF_W-1:0]         flush_off,
  input  logic [CNT_W-1:0]         pop_n,
  output logic [QDEPTH*BYTE_W-1:0] q_bytes,
  output logic [QDEPTH-1:0]        q_start,
  output logic [CNT_W-1:0]         q_count,
  output logic [ADDR_W-1:0]        q_pc,
  output logic                     room
);
  localparam int QBITS = QDEPTH * BYTE_W;

  logic [OFF_W-1:0]  skip;
  logic [CNT_W-1:0]  remain, take, nxt_count;
  logic [QBITS-1:0]  keep_b, blk_b, nxt_b;
  logic [QDEPTH-1:0] keep_s, blk_s, nxt_s;

  assign room = (q_count <= CNT_W'(QDEPTH - BLK));

  always_comb begin
    remain = q_count - pop_n;
    take   = CNT_W'(BLK) - CNT_W'(skip);
    // surviving bytes slide down by the number popped
    keep_b = (q_bytes >> {pop_n, 3'b000}) & ~({QBITS{1'b1}} << {remain, 3'b000});
    keep_s = (q_start >> pop_n) & ~({QDEPTH{1'b1}} << remain);
    // new block drops its leading skip bytes and lands right after them
    blk_b  = ({{(QBITS - BLK*BYTE_W){1'b0}}, push_bytes} >> {skip, 3'b000}) << {remain, 3'b000};
    blk_s  = ({{(QDEPTH - BLK){1'b0}}, push_start} >> skip) << remain;
    nxt_b  = push ? (keep_b | blk_b) : keep_b;
    nxt_s  = push ? (keep_s | blk_s) : keep_s;
    nxt_count = push ? (remain + take) : remain;
  end

  always_ff @(posedge clk) begin
    q_bytes <= nxt_b;
    q_start <= nxt_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_count <= '0;
      skip    <= '0;
      q_pc    <= '0;
    end else if (flush) begin
      q_count <= '0;
      skip    <= flush_off;
    end else begin
      q_count <= nxt_count;
      if (push) skip <= '0;
      if (push && remain == '0) q_pc <= push_addr + ADDR_W'(skip);
      else                      q_pc <= q_pc + ADDR_W'(pop_n);
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(QDEPTH));

  assert_push_room_R1: assert property (@(posedge clk) disable iff (rst)
    push |-> q_count <= CNT_W'(QDEPTH - BLK));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> q_count == '0);
endmodule

// File: rtl/aligner_slots.sv
module aligner_slots
  import insn_align_pkg::*;
#(
  parameter int QDEPTH  = 32,
  parameter int SLOTS   = 5,
  parameter int MAX_LEN = 15,
  parameter int CNT_W   = 6,
  parameter int LEN_W   = 4
) (
  input  logic [QDEPTH*BYTE_W-1:0]        q_bytes,
  input  logic [QDEPTH-1:0]               q_start,
  input  logic [CNT_W-1:0]                q_count,
  output logic [SLOTS-1:0]                s_valid,
  output logic [SLOTS*LEN_W-1:0]          s_len,
  output logic [SLOTS*CNT_W-1:0]          s_off,
  output logic [SLOTS*MAX_LEN*BYTE_W-1:0] s_bytes,
  output logic [CNT_W-1:0]                pop_n
);
  localparam int SBITS = MAX_LEN * BYTE_W;

  logic [CNT_W-1:0]         pos;
  logic                     live, found;
  logic [LEN_W-1:0]         rl;
  logic [QDEPTH-1:0]        vmask, rel;
  logic [QDEPTH*BYTE_W-1:0] window;

  always_comb begin
    pos     = '0;
    live    = (q_count != '0);
    vmask   = ~({QDEPTH{1'b1}} << q_count);
    s_valid = '0;
    s_len   = '0;
    s_off   = '0;
    s_bytes = '0;
    for (int k = 0; k < SLOTS; k++) begin
      // next start marker strictly after this instruction's first byte
      rel   = (q_start & vmask) >> pos;
      rl    = '0;
      found = 1'b0;
      for (int i = MAX_LEN; i >= 1; i--) begin
        if (rel[i]) begin
          rl    = LEN_W'(i);
          found = 1'b1;
        end
      end
      window = q_bytes >> {pos, 3'b000};
      if (live && found) begin
        s_valid[k]                     = 1'b1;
        s_len[k*LEN_W +: LEN_W]        = rl;
        s_off[k*CNT_W +: CNT_W]        = pos;
        s_bytes[k*SBITS +: SBITS]      = window[SBITS-1:0] & ~({SBITS{1'b1}} << {rl, 3'b000});
        pos                            = pos + CNT_W'(rl);
      end else begin
        live = 1'b0;
      end
    end
    pop_n = pos;
  end
endmodule

// File: rtl/aligner_outreg.sv
module aligner_outreg
  import insn_align_pkg::*;
#(
  parameter int SLOTS   = 5,
  parameter int MAX_LEN = 15,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 6,
  parameter int LEN_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clear,
  input  logic [SLOTS-1:0]                s_valid,
  input  logic [SLOTS*LEN_W-1:0]          s_len,
  input  logic [SLOTS*CNT_W-1:0]          s_off,
  input  logic [SLOTS*MAX_LEN*BYTE_W-1:0] s_bytes,
  input  logic [ADDR_W-1:0]               base_pc,
  output logic [SLOTS-1:0]                out_valid,
  output logic [SLOTS*LEN_W-1:0]          out_len,
  output logic [SLOTS*ADDR_W-1:0]         out_pc,
  output logic [SLOTS*MAX_LEN*BYTE_W-1:0] out_bytes
);
  always_ff @(posedge clk) begin
    if (rst || clear) out_valid <= '0;
    else              out_valid <= s_valid;
  end

  always_ff @(posedge clk) begin
    out_len   <= s_len;
    out_bytes <= s_bytes;
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_pc
    always_ff @(posedge clk) begin
      out_pc[k*ADDR_W +: ADDR_W] <= base_pc + ADDR_W'(s_off[k*CNT_W +: CNT_W]);
    end

    assert_len_range_R3: assert property (@(posedge clk) disable iff (rst)
      s_valid[k] |-> (s_len[k*LEN_W +: LEN_W] != '0) &&
                     (s_len[k*LEN_W +: LEN_W] <= LEN_W'(MAX_LEN)));
  end

  assert_slots_packed_R4: assert property (@(posedge clk) disable iff (rst)
    (s_valid & (s_valid + SLOTS'(1))) == '0);

  assert_clear_idle_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> out_valid == '0);
endmodule

// File: rtl/insn_aligner.sv
module insn_aligner
  import insn_align_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int SLOTS     = 5,
  parameter int MAX_LEN   = 15,
  parameter int QDEPTH    = 32,
  parameter int ADDR_W    = 32,
  localparam int CNT_W    = $clog2(QDEPTH + 1),
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int OFF_W    = $clog2(BLK_BYTES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            fetch_valid,
  output logic                            fetch_ready,
  input  logic [ADDR_W-1:0]               fetch_addr,
  input  logic [BLK_BYTES*8-1:0]          fetch_bytes,
  input  logic [BLK_BYTES-1:0]            fetch_start,
  input  logic                            redirect,
  input  logic [OFF_W-1:0]                redirect_off,
  output logic [SLOTS-1:0]                out_valid,
  output logic [SLOTS*LEN_W-1:0]          out_len,
  output logic [SLOTS*ADDR_W-1:0]         out_pc,
  output logic [SLOTS*MAX_LEN*8-1:0]      out_bytes
);
  logic                        room, push;
  logic [QDEPTH*BYTE_W-1:0]    q_bytes;
  logic [QDEPTH-1:0]           q_start;
  logic [CNT_W-1:0]            q_count, pop_n;
  logic [ADDR_W-1:0]           q_pc;
  logic [SLOTS-1:0]            s_valid;
  logic [SLOTS*LEN_W-1:0]      s_len;
  logic [SLOTS*CNT_W-1:0]      s_off;
  logic [SLOTS*MAX_LEN*8-1:0]  s_bytes;

  assign fetch_ready = room & ~redirect;
  assign push        = fetch_valid & fetch_ready;

  aligner_byteq #(
    .BLK(BLK_BYTES), .QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)
  ) u_q (
    .clk(clk), .rst(rst), .push(push), .push_addr(fetch_addr),
    .push_bytes(fetch_bytes), .push_start(fetch_start),
    .flush(redirect), .flush_off(redirect_off), .pop_n(pop_n),
    .q_bytes(q_bytes), .q_start(q_start), .q_count(q_count), .q_pc(q_pc), .room(room)
  );

  aligner_slots #(
    .QDEPTH(QDEPTH), .SLOTS(SLOTS), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_slots (
    .q_bytes(q_bytes), .q_start(q_start), .q_count(q_count),
    .s_valid(s_valid), .s_len(s_len), .s_off(s_off), .s_bytes(s_bytes), .pop_n(pop_n)
  );

  aligner_outreg #(
    .SLOTS(SLOTS), .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_out (
    .clk(clk), .rst(rst), .clear(redirect),
    .s_valid(s_valid), .s_len(s_len), .s_off(s_off), .s_bytes(s_bytes), .base_pc(q_pc),
    .out_valid(out_valid), .out_len(out_len), .out_pc(out_pc), .out_bytes(out_bytes)
  );
endmodule

// File: tb/insn_aligner_bench.sv
`timescale 1ns/1ps
module insn_aligner_bench;
  localparam int BLK = 16, SLOTS = 5, MAXL = 15, QD = 32, AW = 32;
  localparam int LW = 4, OW = 4;
  localparam int NV = 20;
  localparam int LENS [NV] = '{3, 10, 1, 15, 2, 7, 4, 9, 1, 1, 12, 5, 6, 15, 2, 8, 3, 11, 1, 4};

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic                     fetch_valid = 1'b0, fetch_ready;
  logic [AW-1:0]            fetch_addr = '0;
  logic [BLK*8-1:0]         fetch_bytes = '0;
  logic [BLK-1:0]           fetch_start = '0;
  logic                     redirect = 1'b0;
  logic [OW-1:0]            redirect_off = '0;
  logic [SLOTS-1:0]         out_valid;
  logic [SLOTS*LW-1:0]      out_len;
  logic [SLOTS*AW-1:0]      out_pc;
  logic [SLOTS*MAXL*8-1:0]  out_bytes;

  insn_aligner #(.BLK_BYTES(BLK), .SLOTS(SLOTS), .MAX_LEN(MAXL), .QDEPTH(QD), .ADDR_W(AW))
  u_insn_aligner (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_bytes(fetch_bytes), .fetch_start(fetch_start),
    .redirect(redirect), .redirect_off(redirect_off),
    .out_valid(out_valid), .out_len(out_len), .out_pc(out_pc), .out_bytes(out_bytes)
  );

  int checks = 0, miss = 0;
  bit done = 1'b0;
  int exp_pc [64];
  int exp_len [64];
  int exp_n = 0, exp_idx = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_exp();
    exp_n = 0;
    exp_idx = 0;
  endtask

  task automatic add_exp(input int pc, input int len);
    exp_pc[exp_n]  = pc;
    exp_len[exp_n] = len;
    exp_n++;
  endtask

  // stream monitor: every valid slot must be the next expected instruction
  always @(negedge clk) begin
    if (!rst && out_valid != '0) begin
      logic [MAXL*8-1:0] eb;
      chk((out_valid & (out_valid + 5'd1)) == '0, "R4 slots packed", out_valid, 0);
      for (int k = 0; k < SLOTS; k++) begin
        if (out_valid[k]) begin
          if (exp_idx >= exp_n) begin
            chk(1'b0, "R2 unexpected instruction pc", out_pc[k*AW +: AW], -1);
          end else begin
            eb = '0;
            for (int j = 0; j < exp_len[exp_idx]; j++) eb[j*8 +: 8] = 8'(exp_pc[exp_idx] + j);
            chk(out_len[k*LW +: LW] == LW'(exp_len[exp_idx]), "R3 length",
                out_len[k*LW +: LW], exp_len[exp_idx]);
            chk(out_pc[k*AW +: AW] == AW'(exp_pc[exp_idx]), "R6 pc",
                out_pc[k*AW +: AW], exp_pc[exp_idx]);
            chk(out_bytes[k*MAXL*8 +: MAXL*8] == eb, "R5 bytes",
                longint'(out_bytes[k*MAXL*8 +: 64]), longint'(eb[63:0]));
            exp_idx++;
          end
        end
      end
    end
  end

  task automatic send_block(input int addr, input logic [BLK-1:0] st);
    @(negedge clk);
    fetch_addr = AW'(addr);
    for (int j = 0; j < BLK; j++) fetch_bytes[j*8 +: 8] = 8'(addr + j);
    fetch_start = st;
    fetch_valid = 1'b1;
    #0.5;
    while (!fetch_ready) begin
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
    #1 fetch_valid = 1'b0;
  endtask

  task automatic redirect_to(input int off);
    @(negedge clk);
    redirect = 1'b1;
    redirect_off = OW'(off);
    #0.5;
    chk(fetch_ready == 1'b0, "R7 no accept during redirect", fetch_ready, 0);
    @(posedge clk);
    #1 redirect = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R7 outputs cleared after redirect", out_valid, 0);
  endtask

  task automatic expect_done(input string req);
    chk(exp_idx == exp_n, req, exp_idx, exp_n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      miss++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, miss);
      $finish;
    end
  end

  initial begin
    logic [127:0] smap;
    int p;
    repeat (4) @(negedge clk);
    chk(out_valid == '0, "R9 out_valid after reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R9 ready after reset", fetch_ready, 1);

    // table walk: mixed lengths crossing block edges, filler singles after
    clear_exp();
    smap = '0;
    p = 0;
    for (int i = 0; i < NV; i++) begin
      smap[p] = 1'b1;
      add_exp(p, LENS[i]);
      p += LENS[i];
    end
    for (int q = 120; q < 128; q++) smap[q] = 1'b1;
    for (int q = 120; q < 127; q++) add_exp(q, 1);
    for (int b = 0; b < 8; b++) send_block(16 * b, smap[16*b +: 16]);
    repeat (8) @(negedge clk);
    expect_done("R2 R3 whole table stream emitted");

    // five per cycle
    redirect_to(0);
    clear_exp();
    for (int i = 0; i < 15; i++) add_exp(32'h400 + i, 1);
    send_block(32'h400, '1);
    @(negedge clk);
    chk(out_valid == '0, "R10 no output before next edge", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 5'h1F, "R4 five slots cycle 1", out_valid, 5'h1F);
    @(negedge clk);
    chk(out_valid == 5'h1F, "R4 five slots cycle 2", out_valid, 5'h1F);
    @(negedge clk);
    chk(out_valid == 5'h1F, "R4 five slots cycle 3", out_valid, 5'h1F);
    @(negedge clk);
    chk(out_valid == '0, "R2 last instruction waits", out_valid, 0);
    expect_done("R4 fifteen singles emitted");

    // 15-byte straddle and backpressure
    redirect_to(1);
    clear_exp();
    add_exp(32'h201, 15);
    add_exp(32'h210, 4);
    send_block(32'h200, 16'h0002);
    send_block(32'h210, 16'h0011);
    @(negedge clk);
    chk(fetch_ready == 1'b0, "R1 ready low with 31 bytes queued", fetch_ready, 0);
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R1 ready back after pop", fetch_ready, 1);
    repeat (3) @(negedge clk);
    expect_done("R3 R8 straddling 15-byte instruction");

    // flush of leftover bytes and resume offset
    redirect_to(5);
    clear_exp();
    add_exp(32'h305, 3);
    add_exp(32'h308, 4);
    add_exp(32'h30C, 4);
    send_block(32'h300, 16'h1120);
    send_block(32'h310, 16'h0001);
    repeat (4) @(negedge clk);
    expect_done("R7 R8 flush and resume offset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, miss);
    $finish;
  end
endmodule